// File: doc/BRIEF.md
# Subclock Power Gate and Isolation Controller

This block drives the power switches and the output isolation for a combinational logic domain that is switched off inside every period of a slow core clock. While the core clock is high, the registers have already captured their state on the rising edge, so the logic between them can sit at a reduced voltage. Its head-side switch enables follow the clock, and the foot-side enables are their complements. When the clock falls, the domain is powered up again. The isolation cells in front of the always-on registers are released only after a tie-high sense cell inside the gated domain reports that the upper virtual rail is back at a logic 1.

The controller runs on a fast reference clock. The core clock is a level that is synchronous to that reference clock, as it is when a divider running on the same reference clock produces it. Two control inputs are sampled only while the core clock is low, so a change never lands in the middle of a gated phase:

- An active-low override turns gating off completely and keeps isolation quiet.
- A mode select picks between a clamped retention state (sleep and retain both on) and a full cut (sleep on, retain off).

The rail-ready sense is asynchronous and passes through a synchroniser. A sticky late-wake flag is set if the rail has not reported ready within a programmable number of reference cycles after the core clock falls.

Top module: `subclk_gate_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising reference edge, the block resets. After that edge `sleep_o`, `retain_o`, `isolate_o` and `late_wake_o` are 0, `sleep_n_o` and `retain_n_o` are 1, and gating stays disabled until the first reference edge that samples `core_clk_i` low.
- R2: With gating enabled, `sleep_o` equals the `core_clk_i` level sampled at the previous reference edge. `sleep_n_o` is always its complement.
- R3: In clamp mode (sampled `shutdown_i` = 0), `retain_o` equals `sleep_o`. In full-shutdown mode (sampled `shutdown_i` = 1), `retain_o` stays 0 while `sleep_o` is 1. `retain_n_o` is always the complement of `retain_o`, and `retain_o` is never 1 while `sleep_o` is 0.
- R4: With gating enabled, `isolate_o` is 1 one reference cycle after `core_clk_i` is sampled high.
- R5: After `core_clk_i` goes low, `isolate_o` stays 1 until `rail_ready_i` has crossed the two-stage synchroniser. With the default two stages, `isolate_o` falls at the third reference edge after `rail_ready_i` rises.
- R6: When `override_n_i` = 0 has been sampled, `sleep_o`, `retain_o` and `isolate_o` stay 0 across core clock phases.
- R7: `override_n_i` and `shutdown_i` are sampled only at reference edges where `core_clk_i` is low. A change made while `core_clk_i` is high has no effect on the outputs during that high phase.
- R8: Let edge E be the first reference edge that samples `core_clk_i` low after a high phase with gating enabled. If the synchronised ready is still 0, `late_wake_o` becomes 1 at edge E + `wake_limit_i` + 1.
- R9: `late_wake_o` stays 0 when the synchronised ready arrives before that limit. Once set, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_clk_i | input | 1 | Core clock level, synchronous to `clk` |
| override_n_i | input | 1 | Active-low gating disable |
| shutdown_i | input | 1 | 1 = full cut, 0 = clamped retention |
| rail_ready_i | input | 1 | Asynchronous tie-high sense from the gated domain |
| wake_limit_i | input | CNT_W | Reference cycles allowed for the rail to wake |
| sleep_o | output | 1 | Head-side sleep enable |
| sleep_n_o | output | 1 | Foot-side sleep enable (inverse) |
| retain_o | output | 1 | Head-side clamp enable |
| retain_n_o | output | 1 | Foot-side clamp enable (inverse) |
| isolate_o | output | 1 | Output isolation enable |
| late_wake_o | output | 1 | Sticky flag: rail woke late |

## Verification
The timing of each result is fixed relative to its stimulus:

- The switch enables and isolation assertion appear one reference cycle after the core clock level is applied.
- Isolation release appears three cycles after `rail_ready_i` rises: two synchroniser stages plus the isolation register.
- The late-wake flag appears `wake_limit_i` + 1 cycles after the first edge that sees the core clock low.
- A mode change takes effect at the first edge that sees the core clock low, and on the enables one cycle later.

The bench drives every input 1 ns after a rising edge. It counts whole edges with a tick task and samples 1 ns after the edge at which each result is due. Where it matters, it also checks one cycle early to confirm the value has not moved yet.

// File: rtl/sgc_pkg.sv
// Shared types for the subclock power gate controller.
package sgc_pkg;

    // Control state captured during the low phase of the core clock.
    typedef struct packed {
        logic gate_en;   // 1 = subclock gating active (override not asserted)
        logic full_off;  // 1 = cut the rails fully, 0 = clamp them
    } sgc_mode_t;

    localparam sgc_mode_t SGC_MODE_RESET = '{gate_en: 1'b0, full_off: 1'b0};

endpackage

// File: rtl/sgc_mode_latch.sv
// Captures the override and shutdown controls, but only at reference edges
// where the core clock is low, so a gated phase always runs with the mode
// it started with. Assumes core_clk_i is synchronous to clk.
module sgc_mode_latch
    import sgc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      core_clk_i,
    input  logic      override_n_i,
    input  logic      shutdown_i,
    output sgc_mode_t mode_o
);

    sgc_mode_t mode_q;

    // Sample the mode controls during the restored (low) phase only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SGC_MODE_RESET;
        end else if (!core_clk_i) begin
            mode_q <= '{gate_en: override_n_i, full_off: shutdown_i};
        end
    end

    assign mode_o = mode_q;

    // R7: the captured mode never moves on an edge that sees the core clock high.
    a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_i |=> $stable(mode_q));

endmodule

// File: rtl/sgc_rail_sync.sv
// Multi-stage synchroniser for the asynchronous rail-ready sense.
// Assumes STAGES >= 2. The reset value is 0, meaning "not ready".
module sgc_rail_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rail_ready_i,
    output logic ready_o
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] stage_q;

    // Build the flop chain one stage at a time.
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // The first stage samples the raw asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[i] <= 1'b0;
                else        stage_q[i] <= rail_ready_i;
            end
        end else begin : g_next
            // Each later stage resamples the stage before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[i] <= 1'b0;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign ready_o = stage_q[LAST];

    // R5: the synchronised output only ever repeats the previous stage's value.
    a_r5_sync_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(stage_q[LAST-1]));

endmodule

// File: rtl/sgc_gate_drive.sv
// Registers the switch enables and the isolation enable from the core clock
// phase and the captured mode. Isolation is raised with the high phase and
// held after the fall until the synchronised rail-ready sense is 1.
// Assumes core_clk_i is synchronous to clk.
module sgc_gate_drive
    import sgc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      core_clk_i,
    input  sgc_mode_t mode_i,
    input  logic      ready_i,
    output logic      sleep_o,
    output logic      sleep_n_o,
    output logic      retain_o,
    output logic      retain_n_o,
    output logic      isolate_o
);

    logic sleep_q;
    logic retain_q;
    logic iso_q;

    // Switch enables track the core clock phase while gating is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep_q  <= 1'b0;
            retain_q <= 1'b0;
        end else begin
            sleep_q  <= core_clk_i & mode_i.gate_en;
            retain_q <= core_clk_i & mode_i.gate_en & ~mode_i.full_off;
        end
    end

    // Isolation: set in the high phase, held until the rail reports ready.
    always_ff @(posedge clk) begin
        if (!rst_n) iso_q <= 1'b0;
        else        iso_q <= mode_i.gate_en & (core_clk_i | (iso_q & ~ready_i));
    end

    assign sleep_o    = sleep_q;
    assign sleep_n_o  = ~sleep_q;
    assign retain_o   = retain_q;
    assign retain_n_o = ~retain_q;
    assign isolate_o  = iso_q;

    // R3: the clamp is never enabled without the sleep switch.
    a_r3_retain_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        retain_q |-> sleep_q);

    // R4: the domain is never asleep with its outputs unisolated.
    a_r4_iso_covers_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_q |-> iso_q);

    // R5: with gating on, isolation only drops after a ready sense was seen.
    a_r5_release_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(iso_q) && $past(mode_i.gate_en)) |-> $past(ready_i));

    // R6: with override captured, isolation is low on the next edge.
    a_r6_override_no_iso: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i.gate_en |=> !iso_q);

endmodule

// File: rtl/sgc_wake_monitor.sv
// Times the rail wake-up after each falling core clock edge and sets a
// sticky flag when the synchronised ready does not arrive within the limit.
// Assumes the limit is held steady while a wake-up is being timed.
module sgc_wake_monitor #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_clk_i,
    input  logic             gate_en_i,
    input  logic             ready_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             late_o
);

    logic             phase_q;
    logic             wait_q;
    logic [CNT_W-1:0] cnt_q;
    logic             late_q;

    // Remember the previous core clock level to find the falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= core_clk_i;
    end

    // Start the timer at the falling edge; stop it on ready, timeout or a new high phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= 1'b0;
            cnt_q  <= '0;
            late_q <= 1'b0;
        end else if (core_clk_i) begin
            wait_q <= 1'b0;
        end else if (phase_q && gate_en_i) begin
            wait_q <= 1'b1;
            cnt_q  <= '0;
        end else if (wait_q) begin
            if (ready_i) begin
                wait_q <= 1'b0;
            end else if (cnt_q == limit_i) begin
                late_q <= 1'b1;
                wait_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign late_o = late_q;

    // R9: once raised, the late flag holds until reset.
    a_r9_late_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        late_q |=> late_q);

    // R8: the flag only rises while timing a wake-up that has not seen ready.
    a_r8_late_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(late_q) |-> ($past(wait_q) && !$past(ready_i)));

endmodule

// File: rtl/subclk_gate_ctrl.sv
// Top of the subclock power gate and isolation controller. It ties together
// the mode capture, the rail-ready synchroniser, the enable and isolation
// drivers, and the wake-up timer. Everything runs on the reference clock.
// core_clk_i must be a level that is synchronous to that clock.
module subclk_gate_ctrl
    import sgc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_clk_i,
    input  logic             override_n_i,
    input  logic             shutdown_i,
    input  logic             rail_ready_i,
    input  logic [CNT_W-1:0] wake_limit_i,
    output logic             sleep_o,
    output logic             sleep_n_o,
    output logic             retain_o,
    output logic             retain_n_o,
    output logic             isolate_o,
    output logic             late_wake_o
);

    sgc_mode_t mode;
    logic      ready_sync;

    sgc_mode_latch u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .core_clk_i   (core_clk_i),
        .override_n_i (override_n_i),
        .shutdown_i   (shutdown_i),
        .mode_o       (mode)
    );

    sgc_rail_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .rail_ready_i (rail_ready_i),
        .ready_o      (ready_sync)
    );

    sgc_gate_drive u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_clk_i (core_clk_i),
        .mode_i     (mode),
        .ready_i    (ready_sync),
        .sleep_o    (sleep_o),
        .sleep_n_o  (sleep_n_o),
        .retain_o   (retain_o),
        .retain_n_o (retain_n_o),
        .isolate_o  (isolate_o)
    );

    sgc_wake_monitor #(.CNT_W(CNT_W)) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_clk_i (core_clk_i),
        .gate_en_i  (mode.gate_en),
        .ready_i    (ready_sync),
        .limit_i    (wake_limit_i),
        .late_o     (late_wake_o)
    );

    // R2: the sleep enable pair is always complementary.
    a_r2_sleep_pair: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o != sleep_n_o);

endmodule

// File: tb/subclk_gate_ctrl_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module subclk_gate_ctrl_tb;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             core_clk_i = 1'b0;
    logic             override_n_i = 1'b1;
    logic             shutdown_i = 1'b0;
    logic             rail_ready_i = 1'b1;
    logic [CNT_W-1:0] wake_limit_i = 16'd8;
    logic             sleep_o, sleep_n_o, retain_o, retain_n_o, isolate_o, late_wake_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;  // 125 MHz

    subclk_gate_ctrl #(.SYNC_STAGES(2), .CNT_W(CNT_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .core_clk_i   (core_clk_i),
        .override_n_i (override_n_i),
        .shutdown_i   (shutdown_i),
        .rail_ready_i (rail_ready_i),
        .wake_limit_i (wake_limit_i),
        .sleep_o      (sleep_o),
        .sleep_n_o    (sleep_n_o),
        .retain_o     (retain_o),
        .retain_n_o   (retain_n_o),
        .isolate_o    (isolate_o),
        .late_wake_o  (late_wake_o)
    );

    // Advance n rising edges, then step 1 ns past the last one.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        core_clk_i = 1'b0;
        override_n_i = 1'b1;
        shutdown_i = 1'b0;
        rail_ready_i = 1'b1;
        tick(3);
        check("R1 sleep_o reset", sleep_o, 1'b0);
        check("R1 sleep_n_o reset", sleep_n_o, 1'b1);
        check("R1 retain_o reset", retain_o, 1'b0);
        check("R1 retain_n_o reset", retain_n_o, 1'b1);
        check("R1 isolate_o reset", isolate_o, 1'b0);
        check("R1 late_wake_o reset", late_wake_o, 1'b0);
        rst_n = 1'b1;
        tick(2);
    endtask

    task automatic t_clamp_cycle();
        core_clk_i = 1'b1;
        tick(1);
        check("R2 sleep_o high phase", sleep_o, 1'b1);
        check("R2 sleep_n_o high phase", sleep_n_o, 1'b0);
        check("R3 retain_o clamp", retain_o, 1'b1);
        check("R3 retain_n_o clamp", retain_n_o, 1'b0);
        check("R4 isolate_o high phase", isolate_o, 1'b1);
        rail_ready_i = 1'b0;
        tick(4);
        core_clk_i = 1'b0;
        tick(1);
        check("R2 sleep_o low phase", sleep_o, 1'b0);
        check("R3 retain_o low phase", retain_o, 1'b0);
        check("R5 isolate_o held after fall", isolate_o, 1'b1);
        tick(1);
        rail_ready_i = 1'b1;
        tick(2);
        check("R5 isolate_o held during sync", isolate_o, 1'b1);
        tick(1);
        check("R5 isolate_o released", isolate_o, 1'b0);
        tick(8);
        check("R9 late_wake_o stays low on time", late_wake_o, 1'b0);
    endtask

    task automatic t_shutdown_cycle();
        shutdown_i = 1'b1;
        tick(1);
        core_clk_i = 1'b1;
        tick(1);
        check("R3 sleep_o shutdown", sleep_o, 1'b1);
        check("R3 retain_o shutdown", retain_o, 1'b0);
        check("R3 retain_n_o shutdown", retain_n_o, 1'b1);
        rail_ready_i = 1'b0;
        tick(3);
        core_clk_i = 1'b0;
        rail_ready_i = 1'b1;
        tick(2);
        check("R5 isolate_o held shutdown", isolate_o, 1'b1);
        tick(1);
        check("R5 isolate_o released shutdown", isolate_o, 1'b0);
        shutdown_i = 1'b0;
        tick(2);
    endtask

    task automatic t_mid_phase_change();
        core_clk_i = 1'b1;
        tick(1);
        override_n_i = 1'b0;
        shutdown_i = 1'b1;
        tick(2);
        check("R7 sleep_o unchanged mid phase", sleep_o, 1'b1);
        check("R7 retain_o unchanged mid phase", retain_o, 1'b1);
        check("R7 isolate_o unchanged mid phase", isolate_o, 1'b1);
        core_clk_i = 1'b0;
        tick(2);
        core_clk_i = 1'b1;
        tick(1);
        check("R6 sleep_o override", sleep_o, 1'b0);
        check("R6 retain_o override", retain_o, 1'b0);
        check("R6 isolate_o override", isolate_o, 1'b0);
        tick(3);
        check("R6 isolate_o override steady", isolate_o, 1'b0);
        core_clk_i = 1'b0;
        tick(1);
        core_clk_i = 1'b1;
        tick(1);
        check("R6 sleep_o override second phase", sleep_o, 1'b0);
        core_clk_i = 1'b0;
        override_n_i = 1'b1;
        shutdown_i = 1'b0;
        tick(2);
    endtask

    task automatic t_late_wake();
        wake_limit_i = 16'd8;
        core_clk_i = 1'b1;
        tick(1);
        rail_ready_i = 1'b0;
        tick(4);
        core_clk_i = 1'b0;
        tick(1);  // edge E
        tick(8);  // edge E+8
        check("R8 late_wake_o not yet", late_wake_o, 1'b0);
        tick(1);  // edge E+9
        check("R8 late_wake_o set", late_wake_o, 1'b1);
        rail_ready_i = 1'b1;
        tick(5);
        check("R5 isolate_o released after late wake", isolate_o, 1'b0);
        t_clamp_cycle_quiet();
        check("R9 late_wake_o sticky", late_wake_o, 1'b1);
    endtask

    // A clean gated period with no checks; the rail wakes in time.
    task automatic t_clamp_cycle_quiet();
        core_clk_i = 1'b1;
        tick(3);
        core_clk_i = 1'b0;
        tick(6);
    endtask

    initial begin
        t_reset();
        t_clamp_cycle();
        t_shutdown_cycle();
        t_mid_phase_change();
        t_clamp_cycle();
        t_late_wake();
        t_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule